// File: doc/BRIEF.md
# PWM Trip-Zone Protection Stage

This block sits between a PWM generator and the output pins of one complementary channel pair (outputs A and B). It watches a set of fault levels and two software trigger bits and, when a trip is active, replaces each output with a configured override. Trips come in two classes. A cycle-by-cycle trip ends by itself at a chosen timer event once its sources have gone away. A one-shot trip stays latched until software toggles a clear bit.

Each override is a 2-bit action chosen per output, per trip class and per timer count direction. Software force and clear inputs are level bits whose change of value, in either direction, counts as one event. The block reports both trip flags and gives a one-cycle interrupt pulse when either flag rises. Both outputs are registered, so the protected outputs follow the unprotected inputs one clock later.

Top module: `tz_trip_guard`

## Requirements
- R1: While `rstN` is low, both protected outputs, both trip flags and both interrupt pulses are 0.
- R2: With no trip active, each protected output equals its unprotected input of the previous clock cycle.
- R3: In `cbcSrcEn`, bit i (i below NUM_FAULTS) lets fault level i start a cycle-by-cycle trip, and bit NUM_FAULTS lets the software cycle-by-cycle event start one; an enabled source sampled high sets `cbcActive` one cycle later, and a source whose bit is 0 has no effect.
- R4: `ostSrcEn` has the same bit layout and sets `ostActive` one cycle after an enabled source is sampled high.
- R5: Every change of value of `swCbcTog` or `swOstTog`, from 0 to 1 or from 1 to 0, is one software trip event lasting one cycle; the toggle inputs are held at 0 during reset.
- R6: Action codes are 0 pass the input, 1 drive low, 2 drive high, 3 invert the output once when the trip flag rises and hold it after; in `actCfgA`/`actCfgB` bits [1:0] are the cycle-by-cycle action while counting down, [3:2] while counting up, [5:4] the one-shot action while counting down, [7:6] while counting up; `cntDown`=1 means counting down.
- R7: An active cycle-by-cycle trip ends on a cycle where a selected refresh event occurs (`refreshMask` bit 0 selects `tezPulse`, bit 1 selects `tepPulse`) and no enabled cycle-by-cycle source is high; otherwise it stays.
- R8: An active one-shot trip ignores refresh events and ends only on a change of `swClrTog`; if an enabled one-shot source is high in that cycle the trip stays active.
- R9: While both trips are active, the one-shot action decides each output.
- R10: `cbcIrq` and `ostIrq` are high for exactly one cycle, the first cycle in which the matching flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| faultLvl | input | NUM_FAULTS | Fault event levels, 1 = fault present |
| cbcSrcEn | input | NUM_FAULTS+1 | Cycle-by-cycle source enables (top bit: software) |
| ostSrcEn | input | NUM_FAULTS+1 | One-shot source enables (top bit: software) |
| refreshMask | input | 2 | Refresh event select: bit 0 zero event, bit 1 period event |
| tezPulse | input | 1 | Timer-equals-zero pulse |
| tepPulse | input | 1 | Timer-equals-period pulse |
| cntDown | input | 1 | Timer direction, 1 = decrementing |
| swCbcTog | input | 1 | Software cycle-by-cycle trigger, toggle-active |
| swOstTog | input | 1 | Software one-shot trigger, toggle-active |
| swClrTog | input | 1 | One-shot clear, toggle-active |
| actCfgA | input | 8 | Override actions for output A |
| actCfgB | input | 8 | Override actions for output B |
| pwmAIn | input | 1 | Unprotected output A |
| pwmBIn | input | 1 | Unprotected output B |
| pwmAOut | output | 1 | Protected output A |
| pwmBOut | output | 1 | Protected output B |
| cbcActive | output | 1 | Cycle-by-cycle trip active |
| ostActive | output | 1 | One-shot trip active |
| cbcIrq | output | 1 | Pulse on rise of cbcActive |
| ostIrq | output | 1 | Pulse on rise of ostActive |

## Verification
The bench builds the block with the default NUM_FAULTS of 3, so the enable vectors are four bits wide and every fault slot plus the software slot can be selected on its own. This makes it possible to show a disabled fault line being ignored next to an enabled one, and to mix a hardware cycle-by-cycle trip with a software one-shot trip to exercise the priority rule. A behavioural model in the bench follows every cycle, including the count direction at the moment each action is applied.

// File: rtl/tz_pkg.sv
package tz_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } trip_act_e;

  typedef struct packed {
    logic cbcOn;
    logic ostOn;
    logic cbcEnter;
    logic ostEnter;
  } trip_strobe_t;

endpackage

// File: rtl/tz_control.sv
module tz_control
  import tz_pkg::*;
#(
  parameter int NUM_FAULTS = 3,
  localparam int NUM_SRC = NUM_FAULTS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FAULTS-1:0] faultLvl,
  input  logic [NUM_SRC-1:0]    cbcSrcEn,
  input  logic [NUM_SRC-1:0]    ostSrcEn,
  input  logic [1:0]            refreshMask,
  input  logic                  tezPulse,
  input  logic                  tepPulse,
  input  logic                  swCbcTog,
  input  logic                  swOstTog,
  input  logic                  swClrTog,
  output trip_strobe_t          strobes,
  output logic                  cbcActive,
  output logic                  ostActive,
  output logic                  cbcIrq,
  output logic                  ostIrq
);

  logic [2:0] togQ;
  logic swCbcHit, swOstHit, clrHit;
  logic [NUM_SRC-1:0] cbcVec, ostVec;
  logic cbcSrc, ostSrc, refreshHit;
  logic cbcQ, ostQ, cbcPrev, ostPrev;

  // toggle-to-strobe conversion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) togQ <= '0;
    else       togQ <= {swClrTog, swOstTog, swCbcTog};
  end

  assign swCbcHit = swCbcTog ^ togQ[0];
  assign swOstHit = swOstTog ^ togQ[1];
  assign clrHit   = swClrTog ^ togQ[2];

  assign cbcVec = {swCbcHit, faultLvl};
  assign ostVec = {swOstHit, faultLvl};
  assign cbcSrc = |(cbcVec & cbcSrcEn);
  assign ostSrc = |(ostVec & ostSrcEn);
  assign refreshHit = (tezPulse & refreshMask[0]) | (tepPulse & refreshMask[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbcQ    <= 1'b0;
      ostQ    <= 1'b0;
      cbcPrev <= 1'b0;
      ostPrev <= 1'b0;
    end else begin
      cbcPrev <= cbcQ;
      ostPrev <= ostQ;
      if (cbcSrc)          cbcQ <= 1'b1;
      else if (refreshHit) cbcQ <= 1'b0;
      if (ostSrc)          ostQ <= 1'b1;
      else if (clrHit)     ostQ <= 1'b0;
    end
  end

  assign cbcActive = cbcQ;
  assign ostActive = ostQ;
  assign cbcIrq    = cbcQ & ~cbcPrev;
  assign ostIrq    = ostQ & ~ostPrev;

  assign strobes.cbcOn    = cbcQ;
  assign strobes.ostOn    = ostQ;
  assign strobes.cbcEnter = cbcIrq;
  assign strobes.ostEnter = ostIrq;

  p_cbc_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    cbcSrc |=> cbcActive);
  p_ost_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    ostSrc |=> ostActive);
  p_cbc_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cbcActive) |-> ($past(refreshHit) && !$past(cbcSrc)));
  p_ost_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ostActive) |-> ($past(clrHit) && !$past(ostSrc)));
  p_irq_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cbcIrq || ostIrq) |=> (!$past(cbcIrq) || !cbcIrq) && (!$past(ostIrq) || !ostIrq));
  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ostActive) |-> ostIrq);

endmodule

// File: rtl/tz_datapath.sv
module tz_datapath
  import tz_pkg::*;
#(
  parameter int NUM_LANES = 2,
  localparam int CFG_BITS = NUM_LANES * CFG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trip_strobe_t         strobes,
  input  logic                 cntDown,
  input  logic [CFG_BITS-1:0]  actCfg,
  input  logic [NUM_LANES-1:0] pwmIn,
  output logic [NUM_LANES-1:0] pwmOut
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [CFG_W-1:0] cfg;
    trip_act_e ostSel, cbcSel, useSel;
    logic enter, q, qNext;

    assign cfg = actCfg[g*CFG_W +: CFG_W];

    always_comb begin
      ostSel = trip_act_e'(cntDown ? cfg[5:4] : cfg[7:6]);
      cbcSel = trip_act_e'(cntDown ? cfg[1:0] : cfg[3:2]);
      if (strobes.ostOn) begin
        useSel = ostSel;
        enter  = strobes.ostEnter;
      end else if (strobes.cbcOn) begin
        useSel = cbcSel;
        enter  = strobes.cbcEnter;
      end else begin
        useSel = ACT_KEEP;
        enter  = 1'b0;
      end
      unique case (useSel)
        ACT_LOW:  qNext = 1'b0;
        ACT_HIGH: qNext = 1'b1;
        ACT_FLIP: qNext = enter ? ~q : q;
        default:  qNext = pwmIn[g];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= qNext;
    end

    assign pwmOut[g] = q;

    p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.ostOn && !strobes.cbcOn) |=> (pwmOut[g] == $past(pwmIn[g])));
    p_ost_low_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.ostOn && ostSel == ACT_LOW) |=> !pwmOut[g]);
    p_ost_high_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.ostOn && ostSel == ACT_HIGH) |=> pwmOut[g]);
    p_flip_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (useSel == ACT_FLIP && !enter) |=> $stable(pwmOut[g]));
  end

endmodule

// File: rtl/tz_trip_guard.sv
module tz_trip_guard
  import tz_pkg::*;
#(
  parameter int NUM_FAULTS = 3,
  localparam int NUM_SRC = NUM_FAULTS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FAULTS-1:0] faultLvl,
  input  logic [NUM_SRC-1:0]    cbcSrcEn,
  input  logic [NUM_SRC-1:0]    ostSrcEn,
  input  logic [1:0]            refreshMask,
  input  logic                  tezPulse,
  input  logic                  tepPulse,
  input  logic                  cntDown,
  input  logic                  swCbcTog,
  input  logic                  swOstTog,
  input  logic                  swClrTog,
  input  logic [7:0]            actCfgA,
  input  logic [7:0]            actCfgB,
  input  logic                  pwmAIn,
  input  logic                  pwmBIn,
  output logic                  pwmAOut,
  output logic                  pwmBOut,
  output logic                  cbcActive,
  output logic                  ostActive,
  output logic                  cbcIrq,
  output logic                  ostIrq
);

  trip_strobe_t strobes;
  logic [1:0] laneOut;

  tz_control #(.NUM_FAULTS(NUM_FAULTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .faultLvl(faultLvl),
    .cbcSrcEn(cbcSrcEn), .ostSrcEn(ostSrcEn), .refreshMask(refreshMask),
    .tezPulse(tezPulse), .tepPulse(tepPulse),
    .swCbcTog(swCbcTog), .swOstTog(swOstTog), .swClrTog(swClrTog),
    .strobes(strobes), .cbcActive(cbcActive), .ostActive(ostActive),
    .cbcIrq(cbcIrq), .ostIrq(ostIrq)
  );

  tz_datapath #(.NUM_LANES(2)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cntDown(cntDown),
    .actCfg({actCfgB, actCfgA}), .pwmIn({pwmBIn, pwmAIn}), .pwmOut(laneOut)
  );

  assign pwmAOut = laneOut[0];
  assign pwmBOut = laneOut[1];

endmodule

// File: tb/tz_trip_guard_tb.sv
module tz_trip_guard_tb_top;

  localparam int PERIOD = 10;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NF-1:0] faultLvl = '0;
  logic [NF:0] cbcSrcEn = '0, ostSrcEn = '0;
  logic [1:0] refreshMask = '0;
  logic tezPulse = 0, tepPulse = 0, cntDown = 0;
  logic swCbcTog = 0, swOstTog = 0, swClrTog = 0;
  logic [7:0] actCfgA = 8'b01_10_10_01;
  logic [7:0] actCfgB = 8'hFF;
  logic pwmAIn = 0, pwmBIn = 0;
  logic pwmAOut, pwmBOut, cbcActive, ostActive, cbcIrq, ostIrq;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  tz_trip_guard #(.NUM_FAULTS(NF)) dut_i (
    .clk(clk), .rstN(rstN), .faultLvl(faultLvl), .cbcSrcEn(cbcSrcEn),
    .ostSrcEn(ostSrcEn), .refreshMask(refreshMask), .tezPulse(tezPulse),
    .tepPulse(tepPulse), .cntDown(cntDown), .swCbcTog(swCbcTog),
    .swOstTog(swOstTog), .swClrTog(swClrTog), .actCfgA(actCfgA),
    .actCfgB(actCfgB), .pwmAIn(pwmAIn), .pwmBIn(pwmBIn),
    .pwmAOut(pwmAOut), .pwmBOut(pwmBOut), .cbcActive(cbcActive),
    .ostActive(ostActive), .cbcIrq(cbcIrq), .ostIrq(ostIrq)
  );

  // behavioural reference
  bit mA, mB, mCbc, mOst, mCbcQ, mOstQ, mTc, mTo, mTl;

  function automatic bit laneModel(input logic [7:0] cfg, input bit inBit, input bit cur,
                                   input bit ost, input bit cbc, input bit ostIn,
                                   input bit cbcIn, input bit down);
    int code;
    bit entering;
    if (ost) begin
      code = down ? int'(cfg[5:4]) : int'(cfg[7:6]);
      entering = ostIn;
    end else if (cbc) begin
      code = down ? int'(cfg[1:0]) : int'(cfg[3:2]);
      entering = cbcIn;
    end else begin
      code = 0;
      entering = 0;
    end
    if (code == 1) return 1'b0;
    if (code == 2) return 1'b1;
    if (code == 3) return entering ? !cur : cur;
    return inBit;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mA = 0; mB = 0; mCbc = 0; mOst = 0; mCbcQ = 0; mOstQ = 0;
      mTc = 0; mTo = 0; mTl = 0;
    end else begin
      bit hc, ho, hl, cAny, oAny, refr, eC, eO;
      hc = (swCbcTog != mTc);
      ho = (swOstTog != mTo);
      hl = (swClrTog != mTl);
      cAny = hc && cbcSrcEn[NF];
      oAny = ho && ostSrcEn[NF];
      for (int i = 0; i < NF; i++) begin
        if (faultLvl[i] && cbcSrcEn[i]) cAny = 1;
        if (faultLvl[i] && ostSrcEn[i]) oAny = 1;
      end
      refr = (tezPulse && refreshMask[0]) || (tepPulse && refreshMask[1]);
      eC = mCbc && !mCbcQ;
      eO = mOst && !mOstQ;
      mA = laneModel(actCfgA, pwmAIn, mA, mOst, mCbc, eO, eC, cntDown);
      mB = laneModel(actCfgB, pwmBIn, mB, mOst, mCbc, eO, eC, cntDown);
      mCbcQ = mCbc;
      mOstQ = mOst;
      if (cAny) mCbc = 1; else if (refr) mCbc = 0;
      if (oAny) mOst = 1; else if (hl) mOst = 0;
      mTc = swCbcTog; mTo = swOstTog; mTl = swClrTog;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison a quarter period after each edge
  always @(posedge clk) begin
    #(PERIOD/4);
    chk("R6", "pwmAOut model", pwmAOut, mA);
    chk("R6", "pwmBOut model", pwmBOut, mB);
    chk("R7", "cbcActive model", cbcActive, mCbc);
    chk("R8", "ostActive model", ostActive, mOst);
    chk("R10", "cbcIrq model", cbcIrq, mCbc && !mCbcQ);
    chk("R10", "ostIrq model", ostIrq, mOst && !mOstQ);
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1", "pwmAOut", pwmAOut, 0);
    chk("R1", "pwmBOut", pwmBOut, 0);
    chk("R1", "cbcActive", cbcActive, 0);
    chk("R1", "ostIrq", ostIrq, 0);
    rstN = 1;

    // R2 pass-through with one-cycle latency
    pwmAIn = 1; pwmBIn = 0; step(1);
    chk("R2", "A follows", pwmAOut, 1);
    chk("R2", "B follows", pwmBOut, 0);
    pwmAIn = 0; pwmBIn = 1; step(1);
    chk("R2", "A follows", pwmAOut, 0);
    chk("R2", "B follows", pwmBOut, 1);
    pwmBIn = 0; step(1);

    // R3 fault 1 enabled for cycle-by-cycle trip
    cbcSrcEn = 4'b0010; faultLvl = 3'b010; cntDown = 0; step(1);
    chk("R3", "cbcActive set", cbcActive, 1);
    chk("R10", "cbcIrq pulse", cbcIrq, 1);
    step(1);
    chk("R6", "A drive high (cbc up)", pwmAOut, 1);
    chk("R6", "B inverted on entry", pwmBOut, 1);
    chk("R10", "cbcIrq one cycle", cbcIrq, 0);
    step(1);
    chk("R6", "B holds after entry", pwmBOut, 1);
    cntDown = 1; step(1);
    chk("R6", "A drive low (cbc down)", pwmAOut, 0);

    // R7 refresh with source still high, wrong event, then proper event
    refreshMask = 2'b01; tezPulse = 1; step(1); tezPulse = 0;
    chk("R7", "stays while source high", cbcActive, 1);
    faultLvl = 0; tepPulse = 1; step(1); tepPulse = 0;
    chk("R7", "unselected event ignored", cbcActive, 1);
    tezPulse = 1; step(1); tezPulse = 0;
    chk("R7", "cleared at zero event", cbcActive, 0);
    faultLvl = 3'b010; step(1); faultLvl = 0;
    refreshMask = 2'b10; tepPulse = 1; step(1); tepPulse = 0;
    chk("R7", "cleared at period event", cbcActive, 0);

    // R3 disabled fault line
    faultLvl = 3'b100; step(2);
    chk("R3", "disabled fault ignored", cbcActive, 0);
    faultLvl = 0; step(1);

    // R5 software force toggles in both directions
    cbcSrcEn = 4'b1000; swCbcTog = 1; step(1);
    chk("R5", "rise toggle trips", cbcActive, 1);
    tepPulse = 1; step(1); tepPulse = 0;
    chk("R5", "strobe lasts one cycle", cbcActive, 0);
    swCbcTog = 0; step(1);
    chk("R5", "fall toggle trips", cbcActive, 1);
    tepPulse = 1; step(1); tepPulse = 0;

    // R4 / R8 one-shot trip from fault 0
    ostSrcEn = 4'b0001; faultLvl = 3'b001; step(1);
    chk("R4", "ostActive set", ostActive, 1);
    chk("R10", "ostIrq pulse", ostIrq, 1);
    swClrTog = 1; step(1);
    chk("R8", "clear loses to live source", ostActive, 1);
    faultLvl = 0; refreshMask = 2'b11; tezPulse = 1; tepPulse = 1; step(3);
    tezPulse = 0; tepPulse = 0;
    chk("R8", "refresh does not end one-shot", ostActive, 1);
    swClrTog = 0; step(1);
    chk("R8", "clear toggle ends one-shot", ostActive, 0);

    // R9 one-shot overrides cycle-by-cycle
    cntDown = 0; cbcSrcEn = 4'b0010; faultLvl = 3'b010; step(2);
    chk("R9", "cbc drives A high", pwmAOut, 1);
    ostSrcEn = 4'b1000; swOstTog = 1; step(1);
    chk("R4", "software one-shot", ostActive, 1);
    step(1);
    chk("R9", "ost action low wins", pwmAOut, 0);
    chk("R9", "cbc still active", cbcActive, 1);
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule